// File: doc/BRIEF.md
# Self-Timed SRAM Row Write Completion Detector

This block drives one write into a slow, low-leakage SRAM row while the rest of the chip runs on a much faster clock. The array write takes an unknown number of CPU cycles, so the block does not wait for a fixed time. After launching the write, it reads the target row back on every cycle and compares all bits against the data it is writing.

Read-back is single-ended, so a matching compare only shows that one storage node has switched. For that reason the block waits a further programmable replica delay before it reports that the write is complete. If the row never matches within a programmable number of compares, the block ends the write and reports a failure instead. The result is presented as a request that stays high until the CPU acknowledges it. Only after that acknowledgement does the block accept the next write.

Top module: `wr_done_detect`

## Requirements
- R1: After reset, req_ready is 1 and done_req, arr_we and write_fail are 0.
- R2: A write is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only when the block is idle, and it is 0 from the edge after acceptance until done_ack has been taken.
- R3: arr_we rises on the edge that accepts a write. It stays 1, with arr_addr and arr_wdata equal to the accepted address and data, up to and including the edge of the compare that ends the attempt. It is then 0 while done_req is 1.
- R4: Compares use all 40 bits of arr_rdata against the write data. A compare is made on every edge from the second edge after acceptance while the write is in progress. A single differing bit at either end of the row counts as a mismatch.
- R5: When a compare matches on edge E with replica setting N, done_req rises on edge E+N and write_fail is 0. With N=0, done_req rises on edge E itself.
- R6: With timeout setting L (a value of 0 counts as 1), the L-th mismatching compare ends the attempt. done_req rises on that same edge with write_fail=1, and no replica delay is applied.
- R7: If the compare on the edge that would be the L-th mismatch actually matches, the match wins and the write completes successfully.
- R8: done_req and write_fail hold steady until an edge with done_ack=1 is seen. After that edge done_req is 0 and req_ready is 1.
- R9: cfg_replica and cfg_timeout are captured on the acceptance edge. Changing them while a write is in progress has no effect on that write's timing or result.
- R10: write_fail is 1 only while done_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | Block idle; a request is accepted this cycle |
| req_addr | input | AW (6) | Row address of the write |
| req_data | input | DW (40) | Data to write |
| cfg_replica | input | RCW (4) | Replica delay in cycles after a match |
| cfg_timeout | input | TCW (8) | Mismatching compares allowed before failure |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | AW (6) | Array row address |
| arr_wdata | output | DW (40) | Array write data |
| arr_rdata | input | DW (40) | Read-back data of the addressed row |
| done_req | output | 1 | Completion request, held until acknowledged |
| done_ack | input | 1 | CPU acknowledge of completion |
| write_fail | output | 1 | Attempt timed out (valid with done_req) |

## Verification
The successful compare and the timeout limit can land on the same edge. The bench provokes this by setting the array model's write latency so that the first matching read-back arrives on exactly the L-th compare. It then checks that completion comes after the replica delay with no failure flag. In a neighbouring case the latency is one cycle longer, and there the failure must be reported on the limit edge with no replica delay. Every completion edge is predicted from the acceptance edge and the model's commit edge, and is compared cycle-exactly.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_WRITE   = 3'd1,
    WS_COMPARE = 3'd2,
    WS_REPLICA = 3'd3,
    WS_DONE    = 3'd4
  } wcd_state_e;

  function automatic int unsigned lanes_for(input int unsigned width, input int unsigned lane_w);
    return (width + lane_w - 1) / lane_w;
  endfunction

endpackage

// File: rtl/wcd_reset_sync.sv
module wcd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/wcd_row_compare.sv
module wcd_row_compare #(
  parameter int unsigned DW     = 40,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DW-1:0] rd_row,
  input  logic [DW-1:0] wr_row,
  output logic          match
);

  localparam int unsigned LANES = wcd_pkg::lanes_for(DW, LANE_W);
  localparam int unsigned PADW  = LANES * LANE_W;

  logic [PADW-1:0]  rd_pad;
  logic [PADW-1:0]  wr_pad;
  logic [LANES-1:0] lane_eq;

  always_comb begin
    rd_pad = '0;
    wr_pad = '0;
    rd_pad[DW-1:0] = rd_row;
    wr_pad[DW-1:0] = wr_row;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (rd_pad[g*LANE_W +: LANE_W] == wr_pad[g*LANE_W +: LANE_W]);
    end
  endgenerate

  assign match = &lane_eq;

endmodule

// File: rtl/wcd_down_timer.sv
module wcd_down_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          count_en;

  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (load) begin
      count_en = 1'b1;
      count_d  = load_val;
    end else if (dec && (count_q != '0)) begin
      count_en = 1'b1;
      count_d  = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign last = (count_q == CW'(1));

endmodule

// File: rtl/wcd_ctrl.sv
module wcd_ctrl
  import wcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       match,
  input  logic       rep_zero,
  input  logic       tmo_last,
  input  logic       rep_last,
  input  logic       done_ack,
  output wcd_state_e state_q,
  output logic       accept,
  output logic       tmo_dec,
  output logic       rep_load,
  output logic       rep_dec,
  output logic       fail_set,
  output logic       release_o
);

  wcd_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:    if (req_valid) state_d = WS_WRITE;
      WS_WRITE:   state_d = WS_COMPARE;
      WS_COMPARE: begin
        if (match)         state_d = rep_zero ? WS_DONE : WS_REPLICA;
        else if (tmo_last) state_d = WS_DONE;
      end
      WS_REPLICA: if (rep_last) state_d = WS_DONE;
      WS_DONE:    if (done_ack) state_d = WS_IDLE;
      default:    state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign accept    = (state_q == WS_IDLE) && req_valid;
  assign tmo_dec   = (state_q == WS_COMPARE) && !match;
  assign rep_load  = (state_q == WS_COMPARE) && match;
  assign rep_dec   = (state_q == WS_REPLICA);
  assign fail_set  = (state_q == WS_COMPARE) && !match && tmo_last;
  assign release_o = (state_q == WS_DONE) && done_ack;

endmodule

// File: rtl/wr_done_detect.sv
module wr_done_detect
  import wcd_pkg::*;
#(
  parameter int unsigned DW     = 40,
  parameter int unsigned AW     = 6,
  parameter int unsigned RCW    = 4,
  parameter int unsigned TCW    = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic [RCW-1:0] cfg_replica,
  input  logic [TCW-1:0] cfg_timeout,
  output logic           arr_we,
  output logic [AW-1:0]  arr_addr,
  output logic [DW-1:0]  arr_wdata,
  input  logic [DW-1:0]  arr_rdata,
  output logic           done_req,
  input  logic           done_ack,
  output logic           write_fail
);

  logic           rst_n_i;
  wcd_state_e     state_q;
  logic           accept, tmo_dec, rep_load, rep_dec, fail_set, release_w;
  logic           match, tmo_last, rep_last, rep_zero;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [RCW-1:0] repl_q;
  logic           fail_q;
  logic [TCW-1:0] tmo_init;

  wcd_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  wcd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (req_valid),
    .match     (match),
    .rep_zero  (rep_zero),
    .tmo_last  (tmo_last),
    .rep_last  (rep_last),
    .done_ack  (done_ack),
    .state_q   (state_q),
    .accept    (accept),
    .tmo_dec   (tmo_dec),
    .rep_load  (rep_load),
    .rep_dec   (rep_dec),
    .fail_set  (fail_set),
    .release_o (release_w)
  );

  wcd_row_compare #(.DW(DW), .LANE_W(LANE_W)) u_cmp (
    .rd_row (arr_rdata),
    .wr_row (data_q),
    .match  (match)
  );

  assign tmo_init = (cfg_timeout == '0) ? TCW'(1) : cfg_timeout;

  wcd_down_timer #(.CW(TCW)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (accept),
    .load_val (tmo_init),
    .dec      (tmo_dec),
    .last     (tmo_last)
  );

  wcd_down_timer #(.CW(RCW)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (rep_load),
    .load_val (repl_q),
    .dec      (rep_dec),
    .last     (rep_last)
  );

  assign rep_zero = (repl_q == '0);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q <= '0;
      data_q <= '0;
      repl_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
      repl_q <= cfg_replica;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fail_q <= 1'b0;
    end else if (fail_set) begin
      fail_q <= 1'b1;
    end else if (release_w) begin
      fail_q <= 1'b0;
    end
  end

  assign req_ready  = (state_q == WS_IDLE);
  assign arr_we     = (state_q == WS_WRITE) || (state_q == WS_COMPARE);
  assign arr_addr   = addr_q;
  assign arr_wdata  = data_q;
  assign done_req   = (state_q == WS_DONE);
  assign write_fail = fail_q;

endmodule

// File: rtl/wcd_checker.sv
module wcd_checker #(
  parameter int unsigned DW = 40,
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr,
  input logic [DW-1:0] arr_wdata,
  input logic          done_req,
  input logic          done_ack,
  input logic          write_fail
);

  // R2: an accepted request starts the write and drops ready
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (arr_we && !req_ready));

  // R2: never ready while completion is pending
  a_r2_busy_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_req |-> !req_ready);

  // R3: write enable is off while completion is reported
  a_r3_we_off_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_req |-> !arr_we);

  // R3: row address and data do not move during a write
  a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> ($stable(arr_addr) && $stable(arr_wdata)));

  // R8: completion holds until acknowledged
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_req && !done_ack) |=> (done_req && $stable(write_fail)));

  // R8: acknowledge returns the block to idle
  a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_req && done_ack) |=> (!done_req && req_ready));

  // R10: fail flag only alongside completion
  a_r10_fail_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    write_fail |-> done_req);

endmodule

bind wr_done_detect wcd_checker #(.DW(DW), .AW(AW)) i_wcd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .arr_we     (arr_we),
  .arr_addr   (arr_addr),
  .arr_wdata  (arr_wdata),
  .done_req   (done_req),
  .done_ack   (done_ack),
  .write_fail (write_fail)
);

// File: tb/test_wr_done_detect.sv
module test_wr_done_detect;

  localparam int  DW       = 40;
  localparam int  AW       = 6;
  localparam int  RCW      = 4;
  localparam int  TCW      = 8;
  localparam int  ROWS     = 1 << AW;
  localparam time CLK_PER  = 10ns;
  localparam int  WD_LIMIT = 20000;
  localparam longint NEVER = 64'd1 << 40;

  typedef struct packed {
    longint          done_cyc;
    logic            fail;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   data;
    int              we_cyc;
    int              ack_delay;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [AW-1:0]  req_addr = '0;
  logic [DW-1:0]  req_data = '0;
  logic [RCW-1:0] cfg_replica = '0;
  logic [TCW-1:0] cfg_timeout = '0;
  logic           arr_we;
  logic [AW-1:0]  arr_addr;
  logic [DW-1:0]  arr_wdata;
  logic [DW-1:0]  arr_rdata;
  logic           done_req;
  logic           done_ack = 1'b0;
  logic           write_fail;

  logic [DW-1:0]  mem [ROWS];
  int             lat = 1;
  bit             stuck = 1'b0;
  int             wcnt = 0;
  longint         cyc = 0;

  int             checks = 0;
  int             failures = 0;
  bit             summary_done = 1'b0;

  exp_t           sbq[$];
  string          tagq[$];
  bit             in_done = 1'b0;
  bit             ack_sent = 1'b0;
  int             hold = 0;
  logic           cur_fail = 1'b0;
  int             we_seen = 0;
  bit             bus_bad = 1'b0;

  wr_done_detect #(.DW(DW), .AW(AW), .RCW(RCW), .TCW(TCW)) i_wr_done_detect (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_data (req_data), .cfg_replica (cfg_replica),
    .cfg_timeout (cfg_timeout), .arr_we (arr_we), .arr_addr (arr_addr),
    .arr_wdata (arr_wdata), .arr_rdata (arr_rdata), .done_req (done_req),
    .done_ack (done_ack), .write_fail (write_fail)
  );

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // slow array: a row takes lat enabled edges to change
  assign arr_rdata = mem[arr_addr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      wcnt <= 0;
    end else if (arr_we) begin
      wcnt <= wcnt + 1;
      if (!stuck && (wcnt + 1 == lat)) mem[arr_addr] <= arr_wdata;
    end else begin
      wcnt <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: pops expected completions and handles acknowledge
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_we) begin
        we_seen++;
        if (sbq.size() > 0 && (arr_addr != sbq[0].addr || arr_wdata != sbq[0].data)) bus_bad = 1'b1;
      end
      if (ack_sent) begin
        done_ack = 1'b0;
        ack_sent = 1'b0;
        in_done  = 1'b0;
        check(req_ready && !done_req, "R8", "idle after ack", {req_ready, done_req}, 2'b10);
        check(!write_fail, "R10", "fail cleared after ack", write_fail, 0);
      end else if (in_done) begin
        if (hold > 0) begin
          check(done_req && !req_ready && (write_fail == cur_fail), "R8",
                "hold before ack", {done_req, req_ready, write_fail}, {2'b10, cur_fail});
          hold--;
        end else begin
          done_ack = 1'b1;
          ack_sent = 1'b1;
        end
      end else if (done_req) begin
        exp_t  it;
        string tg;
        if (sbq.size() == 0) begin
          check(1'b0, "R5", "unexpected completion", cyc, 0);
        end else begin
          it = sbq.pop_front();
          tg = tagq.pop_front();
          check(cyc == it.done_cyc, tg, "completion edge", cyc, it.done_cyc);
          check(write_fail == it.fail, tg, "fail flag", write_fail, it.fail);
          check(we_seen == it.we_cyc, "R3", "write enable cycles", we_seen, it.we_cyc);
          check(!bus_bad, "R3", "address/data during write", bus_bad, 0);
          if (!it.fail)
            check(mem[it.addr] == it.data, "R3", "row content", mem[it.addr], it.data);
          cur_fail = it.fail;
          hold     = it.ack_delay;
          in_done  = 1'b1;
        end
        we_seen = 0;
        bus_bad = 1'b0;
      end
    end
  end

  // driver: issue one write and push its expected completion
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int l, input bit stk, input int n, input int t,
                          input int ackd, input bit perturb, input string tag);
    exp_t   it;
    longint acc, e0, fcyc;
    int     leff;
    @(negedge clk);
    while (sbq.size() > 0 || in_done || !req_ready) @(negedge clk);
    @(negedge clk);
    lat = l;
    stuck = stk;
    req_addr = a;
    req_data = d;
    cfg_replica = RCW'(n);
    cfg_timeout = TCW'(t);
    req_valid = 1'b1;
    acc  = cyc + 1;
    leff = (t == 0) ? 1 : t;
    if (mem[a] == d)  e0 = acc + 2;
    else if (stk)     e0 = NEVER;
    else              e0 = acc + l + 1;
    fcyc = acc + 1 + leff;
    it.addr = a;
    it.data = d;
    it.ack_delay = ackd;
    if (e0 <= fcyc) begin
      it.done_cyc = e0 + n;
      it.fail     = 1'b0;
      it.we_cyc   = int'(e0 - acc);
    end else begin
      it.done_cyc = fcyc;
      it.fail     = 1'b1;
      it.we_cyc   = int'(fcyc - acc);
    end
    sbq.push_back(it);
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2", "ready low after accept", req_ready, 0);
    if (perturb) begin
      cfg_replica = '0;
      cfg_timeout = TCW'(1);
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !done_req && !arr_we && !write_fail, "R1", "reset outputs",
          {req_ready, done_req, arr_we, write_fail}, 4'b1000);

    do_write(6'd3,  40'hA5_5A0F_F0C3, 3, 1'b0, 2, 10, 0, 1'b0, "R5");
    do_write(6'd7,  40'h12_3456_789A, 1, 1'b0, 0, 5,  0, 1'b0, "R5");
    do_write(6'd3,  40'hA5_5A0F_F0C3, 4, 1'b0, 1, 10, 0, 1'b0, "R4");
    do_write(6'd9,  40'h00_FFFF_0001, 2, 1'b1, 3, 4,  0, 1'b0, "R6");
    do_write(6'd9,  40'h7E_0000_0000, 2, 1'b1, 3, 0,  0, 1'b0, "R6");
    do_write(6'd12, 40'h33_CC33_CC33, 5, 1'b0, 2, 5,  0, 1'b0, "R7");
    do_write(6'd13, 40'h0F_0F0F_0F0F, 6, 1'b0, 2, 5,  0, 1'b0, "R7");
    do_write(6'd7,  40'h92_3456_789A, 2, 1'b0, 1, 8,  0, 1'b0, "R4");
    do_write(6'd7,  40'h92_3456_789B, 3, 1'b0, 1, 8,  0, 1'b0, "R4");
    do_write(6'd20, 40'hDE_ADBE_EF01, 3, 1'b0, 4, 9,  0, 1'b1, "R9");
    do_write(6'd21, 40'h55_AA55_AA55, 2, 1'b0, 1, 6,  5, 1'b0, "R8");
    do_write(6'd22, 40'h01_0203_0405, 7, 1'b1, 0, 3,  4, 1'b0, "R6");

    @(negedge clk);
    while (sbq.size() > 0 || in_done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(req_ready && !done_req && !write_fail, "R10", "final idle",
          {req_ready, done_req, write_fail}, 3'b100);
    finish_run();
  end

endmodule